// File: doc/BRIEF.md
# Load/Store Lane Steering and Extension Unit

This block sits between a 32-bit processor core and a byte-addressed data memory that is one word wide. The core hands it an already computed effective address, an access size, a direction and, for stores, the register value. On a store the block decides which byte lanes of the memory word are written and moves the register's low bytes into those lanes. On a load it takes the word the memory returns, picks out the addressed byte or halfword and widens it to 32 bits, filling with either the sign bit or zeros.

Every access must be naturally aligned: halfwords on even addresses, words on addresses divisible by four. A request that breaks this rule never reaches the memory. One cycle later it is reported as an address fault, with the offending address and a flag that separates a faulting store from a faulting load, so an exception unit can pick the matching cause code. Bytes are numbered big-endian inside the word: byte offset 0 is bits 31:24 and offset 3 is bits 7:0.

Top module: `mem_lane_unit`

## Requirements
- R1: Size encoding on `req_size` is 00 byte, 01 halfword, 10 word, and 11 behaves exactly as word. An aligned word store drives `mem_we` = 1111 and `mem_wdata` = `req_wdata` in the same cycle as the request.
- R2: An aligned halfword store at byte offset 0 drives `mem_we` = 1100 and at offset 2 drives 0011. In both cases `mem_wdata` holds `req_wdata[15:0]` in both halves.
- R3: A byte store at byte offset k drives only `mem_we[3-k]`, so offset 0 maps to bits 31:24. `mem_wdata` holds `req_wdata[7:0]` in all four lanes.
- R4: An aligned word load (size 10 or 11) gives `ld_valid` = 1 and `ld_data` = the `mem_rdata` that was present during the request, one clock after the request.
- R5: A byte load at offset k returns byte lane k of `mem_rdata` (offset 0 = bits 31:24) one clock later. It is sign-extended when `req_unsigned` = 0 and zero-extended when `req_unsigned` = 1.
- R6: A halfword load at offset 0 returns bits 31:16 and at offset 2 returns bits 15:0 of `mem_rdata` one clock later. It is sign-extended when `req_unsigned` = 0 and zero-extended when `req_unsigned` = 1.
- R7: A halfword at an odd address, or a word whose address is not a multiple of 4, is a fault. In the request cycle `mem_we` = 0000 and `mem_re` = 0. One clock later `err_valid` = 1, `err_addr` holds the request address, `err_is_store` equals `req_write`, and `ld_valid` = 0. A byte access never faults.
- R8: While `rst_n` is low, `ld_valid`, `err_valid`, `err_is_store`, `ld_data` and `err_addr` are all cleared to zero at each clock.
- R9: `mem_re` is 1 only for an aligned load, in its request cycle. With `req_valid` = 0, `mem_we` = 0000, `mem_re` = 0, and one clock later `ld_valid` = 0 and `err_valid` = 0. A store never raises `ld_valid`.
- R10: `mem_addr` equals `req_addr` with its two low bits forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Load fills with zeros instead of the sign bit |
| req_addr | input | ADDR_W (32) | Effective byte address |
| req_wdata | input | DATA_W (32) | Register value to store |
| mem_rdata | input | DATA_W (32) | Word read from memory, valid in the request cycle |
| mem_addr | output | ADDR_W (32) | Word-aligned memory address |
| mem_re | output | 1 | Memory read strobe for an aligned load |
| mem_we | output | DATA_W/8 (4) | Byte-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | DATA_W (32) | Store data placed on its lanes |
| ld_valid | output | 1 | Registered load result valid |
| ld_data | output | DATA_W (32) | Extended load result |
| err_valid | output | 1 | Registered alignment fault |
| err_is_store | output | 1 | Fault came from a store |
| err_addr | output | ADDR_W (32) | Faulting byte address |

## Verification
The registered outcome of one request (a load result or an alignment fault) appears in the same cycle in which the next request drives its own write enables or read strobe. The driver therefore issues requests back to back with no idle gap, mixing loads, stores and faulting accesses. In one cycle it checks the lane enables and data of the current request directly at the ports, while the monitor pops the outcome expected from the previous request and compares it. A result that drifts by a cycle, or is lost or repeated, shows up as a mismatch in the queue order.

// File: rtl/lsu_lane_pkg.sv
// Shared types for the load/store lane unit.
// Assumes a memory word of four bytes numbered big-endian.
package lsu_lane_pkg;
    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_WIDE = 2'b11   // treated as a word access
    } acc_size_e;
endpackage

// File: rtl/lsu_align_check.sv
// Natural-alignment test for one access.
// Assumes byte accesses are always legal; halfwords need an even offset,
// words need offset zero within the memory word.
module lsu_align_check
    import lsu_lane_pkg::*;
#(
    parameter int NB    = 4,
    localparam int OFS_W = $clog2(NB)
) (
    input  acc_size_e          size,
    input  logic [OFS_W-1:0]   off,
    output logic               aligned
);
    // Decide legality from the size and low address bits.
    always_comb begin
        unique case (size)
            ACC_BYTE: aligned = 1'b1;
            ACC_HALF: aligned = ~off[0];
            default:  aligned = (off == '0);
        endcase
    end
endmodule

// File: rtl/lsu_store_steer.sv
// Store lane steering: builds byte-lane write enables and places store data.
// Assumes big-endian lanes (offset 0 = most significant byte) and an
// already validated, aligned access when enable is high.
module lsu_store_steer
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic                enable,
    input  acc_size_e           size,
    input  logic [OFS_W-1:0]    off,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NB-1:0]       we,
    output logic [DATA_W-1:0]   lane_data
);
    for (genvar k = 0; k < NB; k++) begin : g_lane
        localparam int LSB = (NB - 1 - k) * 8;
        logic       sel;
        logic [7:0] byte_q;

        // Choose whether lane k is written and what byte it receives.
        always_comb begin
            unique case (size)
                ACC_BYTE: begin
                    sel    = (off == OFS_W'(k));
                    byte_q = wdata[7:0];
                end
                ACC_HALF: begin
                    sel    = (off[OFS_W-1:1] == (OFS_W-1)'(k / 2));
                    byte_q = (k % 2 == 0) ? wdata[15:8] : wdata[7:0];
                end
                default: begin
                    sel    = 1'b1;
                    byte_q = wdata[LSB +: 8];
                end
            endcase
        end

        assign we[NB-1-k]          = enable & sel;
        assign lane_data[LSB +: 8] = byte_q;
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Load extraction: selects the addressed byte or halfword of a memory word
// and widens it with sign or zero fill.
// Assumes big-endian lanes and an even offset for halfwords.
module lsu_load_extract
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  acc_size_e           size,
    input  logic [OFS_W-1:0]    off,
    input  logic                zero_fill,
    input  logic [DATA_W-1:0]   rdata,
    output logic [DATA_W-1:0]   value
);
    logic [DATA_W-1:0] byte_shift;
    logic [DATA_W-1:0] half_shift;
    logic [7:0]        pick_b;
    logic [15:0]       pick_h;

    // Shift the addressed unit down to bit 0.
    always_comb begin
        byte_shift = rdata >> (8 * (NB - 1 - int'(off)));
        half_shift = rdata >> (8 * (NB - 2 - int'({off[OFS_W-1:1], 1'b0})));
        pick_b     = byte_shift[7:0];
        pick_h     = half_shift[15:0];
    end

    // Widen the selected unit to a full word.
    always_comb begin
        unique case (size)
            ACC_BYTE: value = {{(DATA_W-8){~zero_fill & pick_b[7]}}, pick_b};
            ACC_HALF: value = {{(DATA_W-16){~zero_fill & pick_h[15]}}, pick_h};
            default:  value = rdata;
        endcase
    end
endmodule

// File: rtl/mem_lane_unit.sv
// Load/store lane unit between a core and a one-word-wide data memory.
// Drives memory strobes combinationally in the request cycle and registers
// the extended load result or the alignment fault one clock later.
// Assumes mem_rdata is valid in the same cycle as a load request.
module mem_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic                req_unsigned,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_re,
    output logic [NB-1:0]       mem_we,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                ld_valid,
    output logic [DATA_W-1:0]   ld_data,
    output logic                err_valid,
    output logic                err_is_store,
    output logic [ADDR_W-1:0]   err_addr
);
    acc_size_e         size;
    logic [OFS_W-1:0]  off;
    logic              aligned;
    logic              fault;
    logic              store_go;
    logic [DATA_W-1:0] ld_next;

    assign size     = acc_size_e'(req_size);
    assign off      = req_addr[OFS_W-1:0];
    assign fault    = req_valid & ~aligned;
    assign store_go = req_valid & aligned & req_write;
    assign mem_re   = req_valid & aligned & ~req_write;
    assign mem_addr = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

    lsu_align_check #(.NB(NB)) u_align (
        .size    (size),
        .off     (off),
        .aligned (aligned)
    );

    lsu_store_steer #(.DATA_W(DATA_W)) u_store (
        .enable    (store_go),
        .size      (size),
        .off       (off),
        .wdata     (req_wdata),
        .we        (mem_we),
        .lane_data (mem_wdata)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_load (
        .size      (size),
        .off       (off),
        .zero_fill (req_unsigned),
        .rdata     (mem_rdata),
        .value     (ld_next)
    );

    // Register the load result and the fault report of this cycle's request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid     <= 1'b0;
            ld_data      <= '0;
            err_valid    <= 1'b0;
            err_is_store <= 1'b0;
            err_addr     <= '0;
        end else begin
            ld_valid  <= mem_re;
            err_valid <= fault;
            if (mem_re) begin
                ld_data <= ld_next;
            end
            if (fault) begin
                err_addr     <= req_addr;
                err_is_store <= req_write;
            end
        end
    end
endmodule

// File: rtl/mem_lane_unit_chk.sv
// Property checker for mem_lane_unit, attached by bind below.
// Observes ports only; assumes the default four-byte word.
module mem_lane_unit_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int NB    = DATA_W / 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [1:0]          req_size,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                mem_re,
    input logic [NB-1:0]       mem_we,
    input logic                ld_valid,
    input logic                err_valid,
    input logic [ADDR_W-1:0]   err_addr
);
    // R7: lane enables only for a store request
    assert_we_needs_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != '0) |-> (req_valid && req_write));

    // R3: a byte store opens exactly one lane
    assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size == 2'b00) |-> ($countones(mem_we) == 1));

    // R2: an aligned halfword store opens two lanes
    assert_half_two_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size == 2'b01 && !req_addr[0])
        |-> ($countones(mem_we) == 2));

    // R7: an odd halfword reaches neither strobe
    assert_odd_half_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b01 && req_addr[0]) |-> (mem_we == '0 && !mem_re));

    // R7: an odd halfword is reported next cycle with its address
    assert_odd_half_reported_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b01 && req_addr[0])
        |=> (err_valid && err_addr == $past(req_addr)));

    // R7: a result is never both data and fault
    assert_result_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_valid && err_valid));

    // R4: a read strobe yields a load result next cycle
    assert_read_gives_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ld_valid);

    // R9: read strobe only for a load request
    assert_re_needs_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (req_valid && !req_write));
endmodule

bind mem_lane_unit mem_lane_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .ld_valid  (ld_valid),
    .err_valid (err_valid),
    .err_addr  (err_addr)
);

// File: tb/mem_lane_unit_tb.sv
// Scoreboard bench: the driver checks request-cycle strobes and queues the
// expected registered outcome; the monitor pops and compares it next cycle.
`timescale 1ns/1ps
module mem_lane_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_unsigned = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
    logic [31:0] mem_addr, mem_wdata, ld_data, err_addr;
    logic        mem_re, ld_valid, err_valid, err_is_store;
    logic [3:0]  mem_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit          ld_v;
        logic [31:0] ld_d;
        bit          er_v;
        bit          er_st;
        logic [31:0] er_a;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    mem_lane_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .err_valid(err_valid),
        .err_is_store(err_is_store), .err_addr(err_addr)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, check strobes, queue the registered outcome.
    task automatic drive(bit v, bit w, logic [1:0] sz, bit uns,
                         logic [31:0] a, logic [31:0] wd, logic [31:0] rd, string tag);
        bit          ok;
        logic [3:0]  e_we;
        logic [31:0] e_wd, e_ld, sh;
        exp_t        it;
        @(negedge clk);
        req_valid = v; req_write = w; req_size = sz; req_unsigned = uns;
        req_addr = a; req_wdata = wd; mem_rdata = rd;
        #1;
        ok = (sz == 2'b00) || (sz == 2'b01 && !a[0]) || (sz[1] && a[1:0] == 2'b00);
        e_we = 4'b0000;
        e_wd = wd;
        if (v && w && ok) begin
            case (sz)
                2'b00: begin e_we = 4'b1000 >> a[1:0]; e_wd = {4{wd[7:0]}}; end
                2'b01: begin e_we = a[1] ? 4'b0011 : 4'b1100; e_wd = {2{wd[15:0]}}; end
                default: e_we = 4'b1111;
            endcase
            check(tag, {28'h0, mem_we}, {28'h0, e_we});
            check(tag, mem_wdata, e_wd);
        end else begin
            check(v ? tag : "R9", {28'h0, mem_we}, 32'h0);
        end
        check(v ? tag : "R9", {31'h0, mem_re}, {31'h0, v && !w && ok});
        check("R10", mem_addr, {a[31:2], 2'b00});
        sh = rd >> (8 * (3 - a[1:0]));
        case (sz)
            2'b00: e_ld = uns ? {24'h0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
            2'b01: e_ld = a[1] ? (uns ? {16'h0, rd[15:0]} : {{16{rd[15]}}, rd[15:0]})
                               : (uns ? {16'h0, rd[31:16]} : {{16{rd[31]}}, rd[31:16]});
            default: e_ld = rd;
        endcase
        it.ld_v  = v && !w && ok;
        it.ld_d  = e_ld;
        it.er_v  = v && !ok;
        it.er_st = w;
        it.er_a  = a;
        it.tag   = v ? tag : "R9";
        sb_q.push_back(it);
    endtask

    // Monitor: compare registered outputs just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, {31'h0, ld_valid}, {31'h0, e.ld_v});
                check(e.tag, {31'h0, err_valid}, {31'h0, e.er_v});
                if (e.ld_v) check(e.tag, ld_data, e.ld_d);
                if (e.er_v) begin
                    check(e.tag, err_addr, e.er_a);
                    check(e.tag, {31'h0, err_is_store}, {31'h0, e.er_st});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        check("R8", {31'h0, ld_valid}, 32'h0);
        check("R8", {31'h0, err_valid}, 32'h0);
        check("R8", {31'h0, err_is_store}, 32'h0);
        check("R8", ld_data, 32'h0);
        check("R8", err_addr, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: word stores, including size code 11
        drive(1, 1, 2'b10, 0, 32'h0000_0100, 32'hA1B2_C3D4, 32'h0, "R1");
        drive(1, 1, 2'b11, 0, 32'h8000_0204, 32'h1357_9BDF, 32'h0, "R1");
        // R2: halfword stores
        drive(1, 1, 2'b01, 0, 32'h0000_0100, 32'h1234_BEEF, 32'h0, "R2");
        drive(1, 1, 2'b01, 0, 32'h0000_0102, 32'h1234_CAFE, 32'h0, "R2");
        // R3: byte stores at each offset
        for (int k = 0; k < 4; k++)
            drive(1, 1, 2'b00, 0, 32'h0000_0200 + k, 32'hFFFF_FF5A + k, 32'h0, "R3");
        // R4: word loads back to back with stores
        drive(1, 0, 2'b10, 0, 32'h0000_0300, 32'h0, 32'h89AB_CDEF, "R4");
        drive(1, 1, 2'b00, 0, 32'h0000_0301, 32'h0000_0077, 32'h0, "R3");
        drive(1, 0, 2'b11, 1, 32'h0000_0304, 32'h0, 32'hFEDC_BA98, "R4");
        // R5: byte loads, signed and unsigned, every lane
        for (int k = 0; k < 4; k++) begin
            drive(1, 0, 2'b00, 0, 32'h0000_0400 + k, 32'h0, 32'h80FF_7F01, "R5");
            drive(1, 0, 2'b00, 1, 32'h0000_0400 + k, 32'h0, 32'h80FF_7F01, "R5");
        end
        // R6: halfword loads, signed and unsigned
        drive(1, 0, 2'b01, 0, 32'h0000_0500, 32'h0, 32'h8001_7FFE, "R6");
        drive(1, 0, 2'b01, 1, 32'h0000_0500, 32'h0, 32'h8001_7FFE, "R6");
        drive(1, 0, 2'b01, 0, 32'h0000_0502, 32'h0, 32'h7FFE_8001, "R6");
        drive(1, 0, 2'b01, 1, 32'h0000_0502, 32'h0, 32'h7FFE_8001, "R6");
        // R7: misaligned accesses of both directions, back to back
        drive(1, 1, 2'b01, 0, 32'h0000_0601, 32'hDEAD_BEEF, 32'h0, "R7");
        drive(1, 0, 2'b10, 0, 32'h0000_0602, 32'h0, 32'h1111_2222, "R7");
        drive(1, 1, 2'b10, 0, 32'h0000_0603, 32'hDEAD_BEEF, 32'h0, "R7");
        drive(1, 0, 2'b01, 1, 32'hFFFF_FFFF, 32'h0, 32'h3333_4444, "R7");
        drive(1, 1, 2'b11, 0, 32'h0000_0605, 32'h5555_6666, 32'h0, "R7");
        drive(1, 0, 2'b00, 0, 32'h0000_0603, 32'h0, 32'h0000_0080, "R7");
        // R9: idle cycles and a store after a load
        drive(0, 1, 2'b10, 0, 32'h0000_0700, 32'hFFFF_FFFF, 32'h0, "R9");
        drive(1, 0, 2'b10, 0, 32'h0000_0704, 32'h0, 32'hCAFE_F00D, "R4");
        drive(1, 1, 2'b10, 0, 32'h0000_0708, 32'h0BAD_0BAD, 32'h0, "R9");
        drive(0, 0, 2'b00, 0, 32'h0000_0000, 32'h0, 32'h0, "R9");
        drive(0, 0, 2'b00, 0, 32'h0000_0000, 32'h0, 32'h0, "R9");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule